// File: doc/BRIEF.md
# Masked-Write GPIO Port

This block is a 32-pin general-purpose I/O port behind a simple 32-bit register strobe interface. Each pin has a direction bit and an output latch. Software never needs to read a register, change it and write it back. Direction bits are turned on through one write-only register and turned off through another. Output levels are written through two half-port registers, one for pins 0-15 and one for pins 16-31. The upper halfword of each of those writes selects which of the lower sixteen value bits take effect.

The port drives an output-enable vector and an output-data vector to the pads. Incoming pad levels pass through a two-flop synchroniser before software can read them. The output latch is independent of direction. Software can therefore preload a pin's level while the pin is still an input, then enable the driver, and no glitch appears on the pad.

Top module: `gpm_port`

## Requirements
- R1: A write to address 0x00 sets every direction bit whose data bit is 1. Bits written as 0 keep their direction. Direction 1 means output.
- R2: A write to address 0x04 clears every direction bit whose data bit is 1. Bits written as 0 keep their direction.
- R3: Direction changes only through writes to 0x00 or 0x04. Writes to any other address leave it unchanged.
- R4: A write to 0x08 updates output latch bit n (n = 0..15) from data bit n only when data bit n+16 is 1. Other latch bits keep their value.
- R5: A write to 0x0C updates output latch bit 16+n (n = 0..15) from data bit n only when data bit n+16 is 1. Other latch bits keep their value.
- R6: pad_oe equals the direction vector and pad_out equals the output latch in every cycle. The latch keeps its value whatever the direction, so a level loaded while a pin is an input appears once the pin becomes an output.
- R7: After synchronous reset all pins are inputs and all output latches are 0.
- R8: Reading 0x04 returns the direction vector.
- R9: Reading 0x08 returns latch bits 15:0 in bits 15:0. Reading 0x0C returns latch bits 31:16 in bits 15:0. In both cases bits 31:16 read as 0.
- R10: Reading 0x10 returns pad_in as it was two rising clock edges earlier.
- R11: Reads of 0x00 or of any unmapped address return 0. Writes to unmapped addresses, including 0x10, have no effect on any state.
- R12: The read data is combinational from reg_addr in the same cycle, with no read strobe and no side effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_addr | input | 5 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| pad_in | input | 32 | Asynchronous pad input levels |
| pad_oe | output | 32 | Per-pin output enable |
| pad_out | output | 32 | Per-pin output level |

## Verification
The hardest situation to reach is a masked write where the mask and value bits disagree on many pins at once, while the affected pins sit in mixed directions. Only such a write shows that masked-off bits hold and that input pins still take new latch values. Random 32-bit words from a fixed seed provide both the mask and the value, so every write mixes updated and held bits. Directed cases cover the all-zero mask, the all-ones mask and the preload-then-enable sequence. Synchroniser latency is checked cycle by cycle after a directed pad change.

// File: rtl/gpm_pkg.sv
package gpm_pkg;
    localparam int unsigned ADDR_W = 5;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned PINS   = 32;
    localparam int unsigned HALF   = PINS / 2;
    localparam int unsigned NHALF  = PINS / HALF;

    typedef enum logic [ADDR_W-1:0] {
        A_DIR_ON  = 5'h00,
        A_DIR_OFF = 5'h04,
        A_OUT_LO  = 5'h08,
        A_OUT_HI  = 5'h0C,
        A_PIN_IN  = 5'h10
    } gpm_addr_e;

    typedef struct packed {
        logic [HALF-1:0] mask;
        logic [HALF-1:0] value;
    } half_wr_t;

    function automatic logic [HALF-1:0] merge_masked(
        input logic [HALF-1:0] old_q,
        input half_wr_t        wr
    );
        return (old_q & ~wr.mask) | (wr.value & wr.mask);
    endfunction
endpackage

// File: rtl/gpm_dir_reg.sv
module gpm_dir_reg
    import gpm_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            on_stb,
    input  logic            off_stb,
    input  logic [PINS-1:0] bits,
    output logic [PINS-1:0] dir
);
    always_ff @(posedge clk) begin
        if (rst)          dir <= '0;
        else if (on_stb)  dir <= dir | bits;
        else if (off_stb) dir <= dir & ~bits;
    end

    AST_DIR_ON: assert property (@(posedge clk) disable iff (rst)
        on_stb |=> ((dir & $past(bits)) == $past(bits))
                && ((($past(dir) ^ dir) & ~$past(bits)) == '0)); // R1
    AST_DIR_OFF: assert property (@(posedge clk) disable iff (rst)
        (off_stb && !on_stb) |=> ((dir & $past(bits)) == '0)
                && ((($past(dir) ^ dir) & ~$past(bits)) == '0)); // R2
    AST_DIR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(on_stb || off_stb) |=> $stable(dir)); // R3
endmodule

// File: rtl/gpm_out_half.sv
module gpm_out_half
    import gpm_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_stb,
    input  half_wr_t        wr,
    output logic [HALF-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)         q <= '0;
        else if (wr_stb) q <= merge_masked(q, wr);
    end

    AST_HALF_IDLE: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> $stable(q)); // R6
    AST_HALF_MASKED: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> (((q ^ $past(q)) & ~$past(wr.mask)) == '0)
               && (((q ^ $past(wr.value)) & $past(wr.mask)) == '0)); // R4
endmodule

// File: rtl/gpm_in_sync.sv
module gpm_in_sync
    import gpm_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PINS-1:0] raw,
    output logic [PINS-1:0] synced
);
    logic [PINS-1:0] st [STAGES];

    always_ff @(posedge clk) begin
        if (rst) st[0] <= '0;
        else     st[0] <= raw;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) st[s] <= '0;
            else     st[s] <= st[s-1];
        end
    end

    assign synced = st[STAGES-1];

    AST_SYNC_FIRST: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> st[0] == $past(raw)); // R10
endmodule

// File: rtl/gpm_port.sv
module gpm_port
    import gpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_oe,
    output logic [PINS-1:0]   pad_out
);
    logic [PINS-1:0] dir_q;
    logic [PINS-1:0] in_sync;
    logic [HALF-1:0] half_q [NHALF];
    half_wr_t        half_wr;

    assign half_wr = half_wr_t'(reg_wdata);

    gpm_dir_reg u_dir (
        .clk     (clk),
        .rst     (rst),
        .on_stb  (reg_wr && reg_addr == A_DIR_ON),
        .off_stb (reg_wr && reg_addr == A_DIR_OFF),
        .bits    (reg_wdata),
        .dir     (dir_q)
    );

    for (genvar h = 0; h < NHALF; h++) begin : g_half
        localparam logic [ADDR_W-1:0] HADDR = ADDR_W'(A_OUT_LO + 4 * h);
        gpm_out_half u_half (
            .clk    (clk),
            .rst    (rst),
            .wr_stb (reg_wr && reg_addr == HADDR),
            .wr     (half_wr),
            .q      (half_q[h])
        );
        assign pad_out[h*HALF +: HALF] = half_q[h];
    end

    gpm_in_sync #(.STAGES(2)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw    (pad_in),
        .synced (in_sync)
    );

    assign pad_oe = dir_q;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_DIR_OFF: reg_rdata = dir_q;
            A_OUT_LO:  reg_rdata = {{(DATA_W-HALF){1'b0}}, half_q[0]};
            A_OUT_HI:  reg_rdata = {{(DATA_W-HALF){1'b0}}, half_q[1]};
            A_PIN_IN:  reg_rdata = in_sync;
            default:   reg_rdata = '0;
        endcase
    end

    AST_OUT_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == A_OUT_LO || reg_addr == A_OUT_HI)
            |-> reg_rdata[DATA_W-1:HALF] == '0); // R9
    AST_RESET_STATE: assert property (@(posedge clk)
        $past(rst) |-> (pad_oe == '0 && pad_out == '0)); // R7
    AST_OUT_NO_STRAY: assert property (@(posedge clk) disable iff (rst)
        (!reg_wr || !(reg_addr == A_OUT_LO || reg_addr == A_OUT_HI))
            |=> $stable(pad_out)); // R11
endmodule

// File: tb/sim_gpm_port.sv
module sim_gpm_port;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_oe;
    logic [31:0] pad_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [31:0] m_dir = '0;
    logic [31:0] m_out = '0;

    always #2 clk = ~clk;

    gpm_port u0 (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [4:0] a);
        case (a)
            5'h04:   return m_dir;
            5'h08:   return {16'h0, m_out[15:0]};
            5'h0C:   return {16'h0, m_out[31:16]};
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_write(input logic [4:0] a, input logic [31:0] d);
        case (a)
            5'h00: m_dir = m_dir | d;
            5'h04: m_dir = m_dir & ~d;
            5'h08: m_out[15:0]  = (m_out[15:0]  & ~d[31:16]) | (d[15:0] & d[31:16]);
            5'h0C: m_out[31:16] = (m_out[31:16] & ~d[31:16]) | (d[15:0] & d[31:16]);
            default: ;
        endcase
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        model_write(a, d);
    endtask

    task automatic check_all();
        check("R6 pad_oe", pad_oe, m_dir);
        check("R6 pad_out", pad_out, m_out);
        for (int k = 0; k < 4; k++) begin
            logic [4:0] a;
            a = 5'(4 + 4 * k);
            if (a == 5'h10) a = 5'h00;
            reg_addr = a;
            #0.5;
            check(a == 5'h04 ? "R8 dir read" : (a == 5'h00 ? "R11 read 0x00" : "R9 out read"),
                  reg_rdata, exp_read(a));
        end
    endtask

    initial begin
        #20000000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R7: reset state
        check("R7 pad_oe", pad_oe, 32'h0);
        check("R7 pad_out", pad_out, 32'h0);
        check_all();

        // R6: preload while input, then enable
        wr(5'h08, 32'h00FF_00A5);
        check("R6 preload held while input", pad_out, 32'h0000_00A5);
        check("R6 still input", pad_oe, 32'h0);
        wr(5'h00, 32'h0000_00FF);
        check("R1 enable out", pad_oe, 32'h0000_00FF);
        check("R6 level after enable", pad_out, 32'h0000_00A5);
        // R4: zero mask changes nothing
        wr(5'h08, 32'h0000_FFFF);
        check("R4 zero mask", pad_out, m_out);
        // R5: full mask high half
        wr(5'h0C, 32'hFFFF_1234);
        check("R5 full mask", pad_out, 32'h1234_00A5);
        // R11: write to input and unmapped addresses ignored
        wr(5'h10, 32'hFFFF_FFFF);
        wr(5'h1C, 32'hFFFF_FFFF);
        check("R11 unmapped write", pad_out, m_out);
        check("R3 unmapped write dir", pad_oe, m_dir);
        reg_addr = 5'h18; #0.5;
        check("R11 unmapped read", reg_rdata, 32'h0);
        // R2: clear
        wr(5'h04, 32'h0000_000F);
        check("R2 clear dir", pad_oe, 32'h0000_00F0);
        check_all();

        // R10: synchroniser latency
        @(negedge clk);
        pad_in = 32'hDEAD_BEEF;
        reg_addr = 5'h10;
        #0.5; check("R12 R10 before edges", reg_rdata, 32'h0);
        @(negedge clk); #0.5;
        check("R10 after one edge", reg_rdata, 32'h0);
        @(negedge clk); #0.5;
        check("R10 after two edges", reg_rdata, 32'hDEAD_BEEF);

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [4:0] a;
            logic [31:0] d;
            case ($urandom_range(0, 5))
                0: a = 5'h00;
                1: a = 5'h04;
                2: a = 5'h08;
                3: a = 5'h0C;
                4: a = 5'h10;
                default: a = 5'h14;
            endcase
            d = $urandom();
            wr(a, d);
            check("R1 R2 R3 dir", pad_oe, m_dir);
            check("R4 R5 latch", pad_out, m_out);
            if (i % 8 == 0) begin
                logic [31:0] p;
                p = $urandom();
                pad_in = p;
                reg_addr = 5'h10;
                @(negedge clk); @(negedge clk); #0.5;
                check("R10 random pads", reg_rdata, p);
                check_all();
            end
        end

        // R7: reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        m_dir = '0; m_out = '0;
        check("R7 reset dir", pad_oe, 32'h0);
        check("R7 reset out", pad_out, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule